// File: doc/BRIEF.md
# Double-Block Byte SAD Unit

This block is a vector execution datapath that produces packed sums of absolute differences between unsigned bytes. It takes two source vectors of up to four 128-bit lanes, an 8-bit shuffle control, a per-word write mask with a mask-enable and a merge-or-zero select, and the previous destination value used for merging. Within each 128-bit lane it first reorders the dwords of the second source under the shuffle control. The result is an intermediate vector.

Every 64-bit superblock then yields four 16-bit words. The first two words compare the low stationary dword of source 1 against byte windows of the intermediate vector that start at offsets 0 and 1. The last two words compare the high stationary dword against windows that start at offsets 2 and 3. The windows never leave the qword. Masking is then applied at word granularity, and every word above the run-time vector length is cleared.

The unit has one pipeline register. A pulse on `in_valid` yields the full result vector and `out_valid` one clock later, and the registered result holds until the next accepted operation.

Top module: `dbsad_unit`

## Requirements
- R1: Within each 128-bit lane, intermediate dword k (k = 0..3) is the source-2 dword of that lane picked by `shuf_ctl[2k+1:2k]`. The codes 0, 1, 2 and 3 select dwords 0, 1, 2 and 3 of the lane.
- R2: In each qword, result word 0 (bits 15:0) is the sum of |a[i] - t[i]| and result word 1 (bits 31:16) is the sum of |a[i] - t[i+1]|, for i = 0..3. Here a is the source-1 byte and t is the intermediate byte, both indexed within the qword.
- R3: In each qword, result word 2 (bits 47:32) is the sum of |a[4+i] - t[2+i]| and result word 3 (bits 63:48) is the sum of |a[4+i] - t[3+i]|, for i = 0..3.
- R4: Each SAD word is an exact unsigned sum of at most 1020, zero-extended to 16 bits. It never wraps.
- R5: Intermediate bytes are indexed only within the same qword. No window reaches qword byte 7 or any byte of a neighbouring qword.
- R6: A word whose `wmask` bit is 1, or any active word when `mask_en` is 0, takes its computed SAD. `wmask` bit j governs word j, which is result bits 16j+15:16j.
- R7: With `mask_en` = 1 and `zero_mode` = 0, an active word whose mask bit is 0 takes the matching word of `old_dst`.
- R8: With `mask_en` = 1 and `zero_mode` = 1, an active word whose mask bit is 0 becomes zero.
- R9: `vlen_sel` = 0, 1, 2 and 3 give 8, 16, 32 and 32 active words (128, 256, 512 and 512 bits). Words above the active length read zero in every mask mode, and their mask bits have no effect.
- R10: `out_valid` is high exactly in the cycle after an `in_valid` cycle. `result` changes only in the cycle after an `in_valid` cycle.
- R11: After synchronous reset, `out_valid` is 0 and `result` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept the operands this cycle |
| vlen_sel | input | 2 | Active vector length code |
| src_a | input | 512 | Source 1, holding the stationary bytes |
| src_b | input | 512 | Source 2, which is shuffled into the intermediate vector |
| shuf_ctl | input | 8 | Dword shuffle control applied in every lane |
| wmask | input | 32 | Per-word write mask |
| mask_en | input | 1 | Enable write masking |
| zero_mode | input | 1 | 1 = clear unselected words, 0 = merge from old_dst |
| old_dst | input | 512 | Previous destination value, used for merging |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Registered SAD result |

## Verification
The hardest situation to reach from the ports is a sliding window whose bytes come from two different shuffled dwords while the edge of its qword stays unreached. The bench reaches it in two ways. It sweeps all 256 shuffle codes with fresh random operands. It also drives a directed pattern of distinct power-of-two bytes, so that each word sum shows exactly which intermediate bytes were used, with a large byte placed just past the qword edge. The saturated case of 1020 is driven with all-zero stationary bytes against all-ones intermediate bytes. Vector-length clearing is checked with an all-ones mask in merge mode, so that stale merge data would be visible if it leaked through.

// File: rtl/dbsad_pkg.sv
package dbsad_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int DWORD_W = 32;
    localparam int QWORD_W = 64;
    localparam int LANE_W  = 128;

    localparam int DW_PER_LANE = LANE_W / DWORD_W;
    localparam int SEL_W       = $clog2(DW_PER_LANE);
    localparam int CTL_W       = DW_PER_LANE * SEL_W;
    localparam int WIN_BYTES   = DWORD_W / BYTE_W;
    localparam int WORDS_PER_Q = QWORD_W / WORD_W;
    localparam int SAD_MAX     = WIN_BYTES * ((1 << BYTE_W) - 1);
    localparam int SAD_W       = $clog2(SAD_MAX + 1);

    typedef enum logic [1:0] {
        VLEN_128  = 2'd0,
        VLEN_256  = 2'd1,
        VLEN_512  = 2'd2,
        VLEN_512X = 2'd3
    } vlen_e;

    typedef struct packed {
        logic enable;
        logic zeroing;
    } mask_mode_t;

    function automatic logic [BYTE_W-1:0] abs_diff8(input logic [BYTE_W-1:0] x,
                                                    input logic [BYTE_W-1:0] y);
        return (x >= y) ? (x - y) : (y - x);
    endfunction

    function automatic int unsigned words_for_vlen(input vlen_e v);
        case (v)
            VLEN_128: return 8;
            VLEN_256: return 16;
            default:  return 32;
        endcase
    endfunction

endpackage

// File: rtl/dbsad_lane_shuffle.sv
module dbsad_lane_shuffle
    import dbsad_pkg::*;
(
    input  logic [LANE_W-1:0] src_lane,
    input  logic [CTL_W-1:0]  ctl,
    output logic [LANE_W-1:0] tmp_lane
);

    for (genvar k = 0; k < DW_PER_LANE; k++) begin : g_dw
        logic [SEL_W-1:0] sel;
        assign sel = ctl[k*SEL_W +: SEL_W];
        assign tmp_lane[k*DWORD_W +: DWORD_W] = src_lane[DWORD_W*int'(sel) +: DWORD_W];
    end

endmodule

// File: rtl/dbsad_qword_sad.sv
module dbsad_qword_sad
    import dbsad_pkg::*;
(
    input  logic [QWORD_W-1:0] stat_q,
    input  logic [QWORD_W-1:0] slide_q,
    output logic [QWORD_W-1:0] words_q
);

    for (genvar w = 0; w < WORDS_PER_Q; w++) begin : g_word
        localparam int SRC_BASE = (w / 2) * WIN_BYTES;
        localparam int TMP_BASE = w;
        logic [SAD_W-1:0] wsum;

        always_comb begin
            wsum = '0;
            for (int i = 0; i < WIN_BYTES; i++) begin
                wsum = wsum + SAD_W'(abs_diff8(stat_q[(SRC_BASE+i)*BYTE_W +: BYTE_W],
                                               slide_q[(TMP_BASE+i)*BYTE_W +: BYTE_W]));
            end
            AST_SAD_LIMIT: assert (wsum <= SAD_W'(SAD_MAX)) else $error("SAD word above limit"); // R4
        end

        assign words_q[w*WORD_W +: WORD_W] = WORD_W'(wsum);
    end

endmodule

// File: rtl/dbsad_word_mask.sv
module dbsad_word_mask
    import dbsad_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    localparam int CNT_W    = $clog2(NUM_WORDS + 1)
) (
    input  logic [NUM_WORDS*WORD_W-1:0] sad_vec,
    input  logic [NUM_WORDS*WORD_W-1:0] old_vec,
    input  logic [NUM_WORDS-1:0]        wmask,
    input  mask_mode_t                  mode,
    input  logic [CNT_W-1:0]            active_cnt,
    output logic [NUM_WORDS*WORD_W-1:0] res_vec
);

    for (genvar j = 0; j < NUM_WORDS; j++) begin : g_w
        logic in_range;
        logic take_sad;
        assign in_range = active_cnt > CNT_W'(j);
        assign take_sad = !mode.enable || wmask[j];

        always_comb begin
            if (!in_range)
                res_vec[j*WORD_W +: WORD_W] = '0;
            else if (take_sad)
                res_vec[j*WORD_W +: WORD_W] = sad_vec[j*WORD_W +: WORD_W];
            else if (mode.zeroing)
                res_vec[j*WORD_W +: WORD_W] = '0;
            else
                res_vec[j*WORD_W +: WORD_W] = old_vec[j*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/dbsad_unit.sv
module dbsad_unit
    import dbsad_pkg::*;
#(
    parameter int MAX_W = 512,
    localparam int NUM_LANES = MAX_W / LANE_W,
    localparam int NUM_QW    = MAX_W / QWORD_W,
    localparam int NUM_WORDS = MAX_W / WORD_W,
    localparam int CNT_W     = $clog2(NUM_WORDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           vlen_sel,
    input  logic [MAX_W-1:0]     src_a,
    input  logic [MAX_W-1:0]     src_b,
    input  logic [CTL_W-1:0]     shuf_ctl,
    input  logic [NUM_WORDS-1:0] wmask,
    input  logic                 mask_en,
    input  logic                 zero_mode,
    input  logic [MAX_W-1:0]     old_dst,
    output logic                 out_valid,
    output logic [MAX_W-1:0]     result
);

    logic [MAX_W-1:0] tmp_vec;
    logic [MAX_W-1:0] sad_vec;
    logic [MAX_W-1:0] masked_vec;
    logic [CNT_W-1:0] active_cnt;
    mask_mode_t       mode;

    assign mode.enable  = mask_en;
    assign mode.zeroing = zero_mode;

    always_comb begin
        int unsigned req;
        req = words_for_vlen(vlen_e'(vlen_sel));
        if (req > NUM_WORDS)
            active_cnt = CNT_W'(NUM_WORDS);
        else
            active_cnt = CNT_W'(req);
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        dbsad_lane_shuffle u_shuf (
            .src_lane (src_b[l*LANE_W +: LANE_W]),
            .ctl      (shuf_ctl),
            .tmp_lane (tmp_vec[l*LANE_W +: LANE_W])
        );
    end

    for (genvar q = 0; q < NUM_QW; q++) begin : g_qw
        dbsad_qword_sad u_sad (
            .stat_q  (src_a[q*QWORD_W +: QWORD_W]),
            .slide_q (tmp_vec[q*QWORD_W +: QWORD_W]),
            .words_q (sad_vec[q*QWORD_W +: QWORD_W])
        );
    end

    dbsad_word_mask #(.NUM_WORDS(NUM_WORDS)) u_mask (
        .sad_vec    (sad_vec),
        .old_vec    (old_dst),
        .wmask      (wmask),
        .mode       (mode),
        .active_cnt (active_cnt),
        .res_vec    (masked_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= masked_vec;
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("valid not forwarded"); // R10
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid) else $error("spurious valid"); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result)) else $error("result moved without valid"); // R10
    AST_ZERO_ALL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && zero_mode && wmask == '0) |=> result == '0) else $error("zero mode leak"); // R8
    AST_MERGE_ALL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask_en && !zero_mode && wmask == '0 && vlen_sel[1]) |=> result == $past(old_dst)) else $error("merge mismatch"); // R7

    if (MAX_W > LANE_W) begin : g_len_chk
        AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (in_valid && vlen_sel == 2'd0) |=> result[MAX_W-1:LANE_W] == '0) else $error("upper words not cleared"); // R9
    end

endmodule

// File: tb/dbsad_unit_tb.sv
module dbsad_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [1:0]   vlen_sel = 2'd2;
    logic [511:0] src_a = '0;
    logic [511:0] src_b = '0;
    logic [7:0]   shuf_ctl = 8'h00;
    logic [31:0]  wmask = '0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic [511:0] old_dst = '0;
    logic         out_valid;
    logic [511:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbsad_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .vlen_sel(vlen_sel),
        .src_a(src_a), .src_b(src_b), .shuf_ctl(shuf_ctl), .wmask(wmask),
        .mask_en(mask_en), .zero_mode(zero_mode), .old_dst(old_dst),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [511:0] rand512();
        logic [511:0] v;
        for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [511:0] model();
        logic [511:0] tmp, sad, res;
        int nw;
        for (int l = 0; l < 4; l++)
            for (int k = 0; k < 4; k++)
                tmp[l*128 + k*32 +: 32] = src_b[l*128 + 32*int'(shuf_ctl[2*k +: 2]) +: 32];
        for (int q = 0; q < 8; q++)
            for (int w = 0; w < 4; w++) begin
                int s;
                s = 0;
                for (int i = 0; i < 4; i++) begin
                    int x, y;
                    x = int'(src_a[q*64 + ((w < 2) ? 0 : 32) + i*8 +: 8]);
                    y = int'(tmp[q*64 + (w + i)*8 +: 8]);
                    s += (x > y) ? x - y : y - x;
                end
                sad[q*64 + w*16 +: 16] = 16'(s);
            end
        nw = (vlen_sel == 2'd0) ? 8 : (vlen_sel == 2'd1) ? 16 : 32;
        for (int j = 0; j < 32; j++) begin
            if (j >= nw) res[j*16 +: 16] = '0;
            else if (!mask_en || wmask[j]) res[j*16 +: 16] = sad[j*16 +: 16];
            else if (zero_mode) res[j*16 +: 16] = '0;
            else res[j*16 +: 16] = old_dst[j*16 +: 16];
        end
        return res;
    endfunction

    task automatic check_vec(string req, logic [511:0] got, logic [511:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic check_bit(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0b exp=%0b", req, got, exp);
        end
    endtask

    // Operands are already set; pulse valid at a falling edge, check one cycle later.
    task automatic run_op(string req);
        logic [511:0] exp;
        exp = model();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({req, " out_valid"}, out_valid, 1'b1);
        check_vec(req, result, exp);
    endtask

    initial begin
        logic [511:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R11 out_valid after reset", out_valid, 1'b0);
        check_vec("R11 result after reset", result, '0);

        // R1 R2 R3: every shuffle code, random operands, no masking, full length
        for (int c = 0; c < 256; c++) begin
            src_a = rand512(); src_b = rand512(); shuf_ctl = 8'(c);
            vlen_sel = 2'd2; mask_en = 1'b0;
            run_op("R1 R2 R3 shuffle sweep");
        end

        // R2 R3 R5: directed sliding windows, byte 7 and next qword byte 0 are large
        src_a = '0; src_b = '0; shuf_ctl = 8'hE4; mask_en = 1'b0; vlen_sel = 2'd2;
        for (int i = 0; i < 8; i++) src_b[i*8 +: 8] = 8'(1 << i);
        src_b[64 +: 8] = 8'd200;
        run_op("R2 R3 R5 directed");
        check_vec("R2 R3 R5 qword0 words", {448'b0, result[63:0]},
                  {448'b0, 16'd120, 16'd60, 16'd30, 16'd15});

        // R4: saturated SAD 1020 in every word
        src_a = '0; src_b = '1; shuf_ctl = 8'h1B;
        run_op("R4 max");
        check_vec("R4 max value", result, {32{16'd1020}});
        src_a = '1; src_b = '0;
        run_op("R4 max reverse");

        // R6 R7: random masks, merge mode
        for (int n = 0; n < 40; n++) begin
            src_a = rand512(); src_b = rand512(); old_dst = rand512();
            shuf_ctl = 8'($urandom); wmask = $urandom; mask_en = 1'b1; zero_mode = 1'b0;
            vlen_sel = 2'd2;
            run_op("R6 R7 merge");
        end
        wmask = '0;
        run_op("R7 merge all old");
        check_vec("R7 equals old_dst", result, old_dst);

        // R6 R8: random masks, zero mode
        for (int n = 0; n < 40; n++) begin
            src_a = rand512(); src_b = rand512(); old_dst = rand512();
            shuf_ctl = 8'($urandom); wmask = $urandom; mask_en = 1'b1; zero_mode = 1'b1;
            run_op("R6 R8 zero");
        end
        wmask = '0;
        run_op("R8 zero all");
        check_vec("R8 all zero", result, '0);
        mask_en = 1'b0; zero_mode = 1'b1; wmask = '0;
        run_op("R6 mask disabled");

        // R9: each length code, all-ones mask in merge mode, random old data
        for (int v = 0; v < 4; v++) begin
            for (int n = 0; n < 6; n++) begin
                src_a = rand512(); src_b = rand512(); old_dst = rand512();
                shuf_ctl = 8'($urandom); vlen_sel = 2'(v);
                wmask = (n == 0) ? '1 : $urandom; mask_en = 1'(n % 2); zero_mode = 1'(n / 3);
                run_op("R9 vlen");
            end
        end
        vlen_sel = 2'd0; src_a = '0; src_b = '1; mask_en = 1'b1; zero_mode = 1'b0;
        wmask = '1; old_dst = '1;
        run_op("R9 short");
        check_vec("R9 upper cleared", {result[511:128], 128'b0}, '0);

        // R10: no valid -> no out_valid, result held
        held = result;
        src_a = rand512(); src_b = rand512(); vlen_sel = 2'd2; mask_en = 1'b0;
        @(negedge clk);
        check_bit("R10 no valid", out_valid, 1'b0);
        check_vec("R10 hold", result, held);
        @(negedge clk);
        check_vec("R10 hold again", result, held);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 got=hung exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule